// File: doc/BRIEF.md
# Backplane Slave Data-Transfer Controller

This block is the slave side of an asynchronous backplane data-transfer bus. It is built for a synchronous fabric clock. Four bus control lines pass through a synchroniser: the address strobe, the two data strobes and the direction line. The block watches for a new address strobe and captures the address, the address-modifier code, the interrupt-acknowledge flag and the long-word flag. It then decides whether the cycle is a single 16-bit access to this board, in either the short (16-bit address) space or the standard (24-bit address) space.

On a match, the block pulls its board-select output low and waits until both data strobes are low. It then issues a one-cycle read or write on a local register-file port. For a read, it puts the returned word on the data bus before it acknowledges. It holds the acknowledge low until the master raises both strobes. After that it drives the acknowledge high for a fixed number of clocks (the rescind phase) and then releases it. A cycle that does not match is left entirely alone.

The bidirectional data and acknowledge lines are split into a value output and an enable output, so the pad ring can build the tri-state buffers.

Top module: `vme_slave_xfer`

## Requirements
- R1: While reset is high and in the clock after it, `dtack_oe` and `bus_data_oe` are 0, `board_sel_n` is 1, and `reg_we` and `reg_re` are 0.
- R2: The block accepts a cycle in the short space when all of the following hold: the modifier code is 0x29 or 0x2D, byte-address bits 15 down to REG_AW+1 equal those of A16_BASE, the interrupt-acknowledge line is high and the long-word line is high. Address lines above bit 15 are ignored. The register index is byte-address bits REG_AW down to 1.
- R3: The block accepts a cycle in the standard space when all of the following hold: the modifier code is 0x39 or 0x3D, byte-address bits 23 down to REG_AW+1 equal those of A24_BASE, the interrupt-acknowledge line is high and the long-word line is high.
- R4: A cycle that fails the R2 and R3 conditions is ignored for its whole length. This covers a wrong address, a wrong modifier code, interrupt-acknowledge low, or long-word low. For such a cycle, `dtack_oe` and `bus_data_oe` stay 0, `board_sel_n` stays 1, and no register strobe is issued.
- R5: No register access starts until both data strobes are seen low. A cycle with only one strobe low never reaches the register port.
- R6: A matched write gives exactly one `reg_we` pulse. `reg_wdata` carries the bus data, and the pulse occurs before the acknowledge goes low.
- R7: A matched read gives one `reg_re` pulse. `bus_data_oe` is high, with the register word on `bus_data_out`, from at least one clock before the acknowledge goes low. It drops when both strobes are seen high.
- R8: The acknowledge stays driven low until both strobes are seen high. It is then driven high for exactly RESCIND_CYC clocks, after which `dtack_oe` falls.
- R9: `board_sel_n` is low from decode of a matched cycle until the address strobe is seen high again, and it is low whenever the acknowledge is driven.
- R10: If the address strobe rises on a matched cycle before both data strobes fall, the cycle is dropped with no register access. The next cycle is then handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes, active low |
| bus_write_n | input | 1 | Direction: 1 read, 0 write |
| bus_am | input | 6 | Address-modifier code |
| bus_addr | input | 23 | Address lines, byte-address bits 23..1 |
| bus_iack_n | input | 1 | Interrupt-acknowledge flag, active low |
| bus_lword_n | input | 1 | Long-word flag, active low |
| bus_data_in | input | 16 | Data bus as seen at the pads |
| bus_data_out | output | 16 | Read data toward the pads |
| bus_data_oe | output | 1 | Data bus drive enable |
| dtack_oe | output | 1 | Acknowledge drive enable |
| dtack_level | output | 1 | Acknowledge level while driven (0 acknowledge, 1 rescind) |
| board_sel_n | output | 1 | Board selected, active low |
| reg_addr | output | REG_AW | Register index |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe; data expected in the same cycle |
| reg_rdata | input | 16 | Register read data |

## Verification
The bench targets the boundaries of the decoder:
- Addresses just outside the base window would be wrongly acknowledged by a decoder with a short compare.
- Short-space cycles with random upper address lines would be refused by a decoder that compares too many bits.
- Interrupt-acknowledge or long-word cycles would get a bus response from a decoder that ignores those flags.

It also probes the handshake:
- A single strobe held low catches a controller that starts on one strobe.
- An address strobe pulled back before any data strobe catches a stray access or a stuck select.
- The rescind phase is timed to the exact clock count.
- Read data is checked while the acknowledge is low, which catches data presented late or lost.

// File: rtl/vme_pkg.sv
package vme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ACCESS,
    ST_ACK,
    ST_WAIT_DS_HIGH,
    ST_RESCIND,
    ST_RELEASE
  } xfer_st_t;

  localparam logic [5:0] AM_SHORT_USER = 6'h29;
  localparam logic [5:0] AM_SHORT_SUPV = 6'h2D;
  localparam logic [5:0] AM_STD_USER   = 6'h39;
  localparam logic [5:0] AM_STD_SUPV   = 6'h3D;

endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/vme_addr_decode.sv
module vme_addr_decode
  import vme_pkg::*;
#(
  parameter int          REG_AW   = 4,
  parameter logic [15:0] A16_BASE = 16'hC000,
  parameter logic [23:0] A24_BASE = 24'h3A0000,
  localparam int         LO       = REG_AW + 1
) (
  input  logic [5:0]    am,
  input  logic [23:LO]  addr_hi,
  input  logic          iack_n,
  input  logic          lword_n,
  output logic          hit,
  output logic          std_space
);

  logic am_short, am_std, win_short, win_std, plain;

  always_comb begin
    am_short  = (am == AM_SHORT_USER) || (am == AM_SHORT_SUPV);
    am_std    = (am == AM_STD_USER)   || (am == AM_STD_SUPV);
    win_short = (addr_hi[15:LO] == A16_BASE[15:LO]);
    win_std   = (addr_hi[23:LO] == A24_BASE[23:LO]);
    plain     = iack_n && lword_n;
    std_space = am_std;
    hit       = plain && ((am_short && win_short) || (am_std && win_std));
  end

endmodule

// File: rtl/vme_xfer_ctrl.sv
module vme_xfer_ctrl
  import vme_pkg::*;
#(
  parameter int  REG_AW      = 4,
  parameter int  RESCIND_CYC = 2,
  localparam int LO          = REG_AW + 1,
  localparam int RC_W        = $clog2(RESCIND_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_s,
  input  logic [1:0]        ds_s,
  input  logic              wr_s,
  input  logic [23:1]       bus_addr,
  input  logic [5:0]        bus_am,
  input  logic              bus_iack_n,
  input  logic              bus_lword_n,
  input  logic [15:0]       bus_data_in,
  input  logic              hit,
  output logic [5:0]        lat_am,
  output logic [23:LO]      lat_addr_hi,
  output logic              lat_iack_n,
  output logic              lat_lword_n,
  output logic [REG_AW-1:0] reg_addr,
  output logic [15:0]       reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [15:0]       reg_rdata,
  output logic [15:0]       data_out,
  output logic              data_oe,
  output logic              dtack_oe,
  output logic              dtack_o,
  output logic              board_sel_n
);

  xfer_st_t        st;
  logic            as_q;
  logic            cyc_wr;
  logic [RC_W-1:0] rc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      as_q        <= 1'b1;
      cyc_wr      <= 1'b0;
      rc          <= '0;
      lat_am      <= '0;
      lat_addr_hi <= '0;
      lat_iack_n  <= 1'b1;
      lat_lword_n <= 1'b1;
      reg_addr    <= '0;
      reg_wdata   <= '0;
      reg_we      <= 1'b0;
      reg_re      <= 1'b0;
      data_out    <= '0;
      data_oe     <= 1'b0;
      dtack_oe    <= 1'b0;
      dtack_o     <= 1'b1;
      board_sel_n <= 1'b1;
    end else begin
      as_q <= as_s;
      unique case (st)
        ST_IDLE: begin
          if (!as_s && as_q) begin
            lat_am      <= bus_am;
            lat_addr_hi <= bus_addr[23:LO];
            lat_iack_n  <= bus_iack_n;
            lat_lword_n <= bus_lword_n;
            reg_addr    <= bus_addr[REG_AW:1];
            st          <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (!hit) begin
            st <= ST_RELEASE;
          end else if (as_s) begin
            board_sel_n <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            board_sel_n <= 1'b0;
            if (ds_s == 2'b00) begin
              cyc_wr <= !wr_s;
              if (!wr_s) begin
                reg_we    <= 1'b1;
                reg_wdata <= bus_data_in;
              end else begin
                reg_re <= 1'b1;
              end
              st <= ST_ACCESS;
            end
          end
        end
        ST_ACCESS: begin
          reg_we <= 1'b0;
          reg_re <= 1'b0;
          if (!cyc_wr) begin
            data_out <= reg_rdata;
            data_oe  <= 1'b1;
          end
          st <= ST_ACK;
        end
        ST_ACK: begin
          dtack_oe <= 1'b1;
          dtack_o  <= 1'b0;
          st       <= ST_WAIT_DS_HIGH;
        end
        ST_WAIT_DS_HIGH: begin
          if (ds_s == 2'b11) begin
            data_oe <= 1'b0;
            dtack_o <= 1'b1;
            rc      <= '0;
            st      <= ST_RESCIND;
          end
        end
        ST_RESCIND: begin
          if (rc == RC_W'(RESCIND_CYC - 1)) begin
            dtack_oe <= 1'b0;
            st       <= ST_RELEASE;
          end else begin
            rc <= rc + 1'b1;
          end
        end
        ST_RELEASE: begin
          if (as_s) begin
            board_sel_n <= 1'b1;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we); // R6
  AST_STROBES_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_we || reg_re) |-> ($past(ds_s) == 2'b00)); // R5
  AST_ACCESS_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACCESS) |-> (lat_iack_n && lat_lword_n)); // R4
  AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
    (dtack_oe && !dtack_o && !cyc_wr) |-> data_oe); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dtack_oe && !dtack_o && ds_s != 2'b11) |=> (dtack_oe && !dtack_o)); // R8
  AST_RESCIND_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_oe) |-> $past(dtack_o)); // R8

endmodule

// File: rtl/vme_slave_xfer.sv
module vme_slave_xfer #(
  parameter int          REG_AW      = 4,
  parameter int          RESCIND_CYC = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] A16_BASE    = 16'hC000,
  parameter logic [23:0] A24_BASE    = 24'h3A0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_as_n,
  input  logic [1:0]        bus_ds_n,
  input  logic              bus_write_n,
  input  logic [5:0]        bus_am,
  input  logic [23:1]       bus_addr,
  input  logic              bus_iack_n,
  input  logic              bus_lword_n,
  input  logic [15:0]       bus_data_in,
  output logic [15:0]       bus_data_out,
  output logic              bus_data_oe,
  output logic              dtack_oe,
  output logic              dtack_level,
  output logic              board_sel_n,
  output logic [REG_AW-1:0] reg_addr,
  output logic [15:0]       reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [15:0]       reg_rdata
);

  localparam int LO = REG_AW + 1;

  logic [3:0]   ctl_s;
  logic         as_s, wr_s;
  logic [1:0]   ds_s;
  logic [5:0]   lat_am;
  logic [23:LO] lat_addr_hi;
  logic         lat_iack_n, lat_lword_n, hit, std_space;

  vme_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_as_n, bus_ds_n, bus_write_n}),
    .q   (ctl_s)
  );

  assign as_s = ctl_s[3];
  assign ds_s = ctl_s[2:1];
  assign wr_s = ctl_s[0];

  vme_addr_decode #(.REG_AW(REG_AW), .A16_BASE(A16_BASE), .A24_BASE(A24_BASE)) u_dec (
    .am        (lat_am),
    .addr_hi   (lat_addr_hi),
    .iack_n    (lat_iack_n),
    .lword_n   (lat_lword_n),
    .hit       (hit),
    .std_space (std_space)
  );

  vme_xfer_ctrl #(.REG_AW(REG_AW), .RESCIND_CYC(RESCIND_CYC)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .as_s        (as_s),
    .ds_s        (ds_s),
    .wr_s        (wr_s),
    .bus_addr    (bus_addr),
    .bus_am      (bus_am),
    .bus_iack_n  (bus_iack_n),
    .bus_lword_n (bus_lword_n),
    .bus_data_in (bus_data_in),
    .hit         (hit),
    .lat_am      (lat_am),
    .lat_addr_hi (lat_addr_hi),
    .lat_iack_n  (lat_iack_n),
    .lat_lword_n (lat_lword_n),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .reg_rdata   (reg_rdata),
    .data_out    (bus_data_out),
    .data_oe     (bus_data_oe),
    .dtack_oe    (dtack_oe),
    .dtack_o     (dtack_level),
    .board_sel_n (board_sel_n)
  );

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!dtack_oe && !bus_data_oe && board_sel_n && !reg_we && !reg_re)); // R1
  AST_ACK_SELECTED: assert property (@(posedge clk) disable iff (rst)
    dtack_oe |-> !board_sel_n); // R9
  AST_STD_AM_OK: assert property (@(posedge clk) disable iff (rst)
    (hit && std_space) |-> (lat_am[5:4] == 2'b11)); // R3

endmodule

// File: tb/tb_vme_slave_xfer.sv
module tb_vme_slave_xfer;

  localparam int          AW  = 4;
  localparam int          RSC = 2;
  localparam logic [15:0] B16 = 16'hC000;
  localparam logic [23:0] B24 = 24'h3A0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, write_n = 1'b1, iack_n = 1'b1, lword_n = 1'b1;
  logic [1:0]  ds_n = 2'b11;
  logic [5:0]  am = '0;
  logic [23:1] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout, reg_wdata, reg_rdata;
  logic data_oe, dtack_oe, dtack_level, board_sel_n, reg_we, reg_re;
  logic [AW-1:0] reg_addr;

  int total = 0, bad = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [15:0] last_wdata = '0;
  logic [AW-1:0] last_waddr = '0;
  logic [15:0] regmem [1<<AW];
  logic [15:0] exp_mem [1<<AW];

  always #4 clk = ~clk;

  vme_slave_xfer #(.REG_AW(AW), .RESCIND_CYC(RSC), .A16_BASE(B16), .A24_BASE(B24)) dut (
    .clk(clk), .rst(rst), .bus_as_n(as_n), .bus_ds_n(ds_n), .bus_write_n(write_n),
    .bus_am(am), .bus_addr(addr), .bus_iack_n(iack_n), .bus_lword_n(lword_n),
    .bus_data_in(din), .bus_data_out(dout), .bus_data_oe(data_oe),
    .dtack_oe(dtack_oe), .dtack_level(dtack_level), .board_sel_n(board_sel_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1<<AW); i++) regmem[i] <= '0;
    end else if (reg_we) begin
      regmem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = regmem[reg_addr];

  always @(posedge clk) begin
    if (!rst && reg_we) begin
      we_cnt     <= we_cnt + 1;
      last_wdata <= reg_wdata;
      last_waddr <= reg_addr;
    end
    if (!rst && reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [5:0] m, input logic [23:1] a,
                                 input bit ia, input bit lw);
    logic [23:0] ba;
    ba = {a, 1'b0};
    if (!ia || !lw) return 1'b0;
    if (m == 6'h29 || m == 6'h2D) return (ba[15:0] >> (AW+1)) == (B16 >> (AW+1));
    if (m == 6'h39 || m == 6'h3D) return (ba >> (AW+1)) == (B24 >> (AW+1));
    return 1'b0;
  endfunction

  task automatic idle_bus();
    @(negedge clk);
    ds_n = 2'b11; as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cycle(input bit wr, input logic [5:0] m, input logic [23:1] a,
                           input logic [15:0] d, input bit ia, input bit lw,
                           input string req);
    bit hit, got, any;
    int we0, re0, hi;
    logic [AW-1:0] idx;
    hit = exp_hit(m, a, ia, lw);
    idx = a[AW:1];
    @(negedge clk);
    am = m; addr = a; iack_n = ia; lword_n = lw; write_n = !wr; din = d;
    we0 = we_cnt; re0 = re_cnt;
    @(negedge clk); as_n = 1'b0;
    repeat (3) @(negedge clk);
    ds_n = 2'b00;
    if (hit) begin
      got = 1'b0;
      for (int i = 0; i < 20 && !got; i++) begin
        @(negedge clk);
        got = dtack_oe && !dtack_level;
      end
      check(got, req, "acknowledge driven low (R8)", int'(got), 1);
      check(!board_sel_n, req, "board select during ack (R9)", int'(board_sel_n), 0);
      if (wr) begin
        check(we_cnt == we0 + 1, req, "write pulse count (R6)", we_cnt - we0, 1);
        check(last_wdata == d && last_waddr == idx, req, "write data/index (R6)",
              int'(last_wdata), int'(d));
        exp_mem[idx] = d;
      end else begin
        check(re_cnt == re0 + 1, req, "read pulse count (R7)", re_cnt - re0, 1);
        check(data_oe && dout == exp_mem[idx], req, "read data on bus (R7)",
              int'(dout), int'(exp_mem[idx]));
      end
      repeat (4) @(negedge clk);
      check(dtack_oe && !dtack_level, req, "ack held while strobes low (R8)",
            int'(dtack_level), 0);
      ds_n = 2'b11;
      hi = 0;
      got = 1'b0;
      for (int i = 0; i < 30 && !got; i++) begin
        @(negedge clk);
        if (dtack_oe && dtack_level) hi++;
        if (!dtack_oe) got = 1'b1;
      end
      check(got && hi == RSC, req, "rescind length (R8)", hi, RSC);
      check(!data_oe, req, "data enable dropped (R7)", int'(data_oe), 0);
      check(!board_sel_n, req, "select held until strobe high (R9)", int'(board_sel_n), 0);
      @(negedge clk); as_n = 1'b1;
      repeat (4) @(negedge clk);
      check(board_sel_n, req, "select released (R9)", int'(board_sel_n), 1);
    end else begin
      any = 1'b0;
      repeat (15) begin
        @(negedge clk);
        if (dtack_oe || data_oe || !board_sel_n) any = 1'b1;
      end
      check(!any, req, "ignored cycle quiet (R4)", int'(any), 0);
      check(we_cnt == we0 && re_cnt == re0, req, "ignored cycle no strobe (R4)",
            we_cnt + re_cnt - we0 - re0, 0);
      idle_bus();
    end
  endtask

  function automatic logic [5:0] pick_am(input int k);
    case (k)
      0: return 6'h29;
      1: return 6'h2D;
      2: return 6'h39;
      3: return 6'h3D;
      4: return 6'h09;
      default: return 6'h3F;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    int any;
    logic [23:1] a;
    seed_v = $urandom(32'h5EED);
    for (int i = 0; i < (1<<AW); i++) exp_mem[i] = '0;
    repeat (5) @(negedge clk);
    check(!dtack_oe && !data_oe && board_sel_n && !reg_we && !reg_re, "R1",
          "outputs in reset", int'({dtack_oe, data_oe, board_sel_n}), 1);
    rst = 1'b0;
    @(negedge clk);
    check(!dtack_oe && !data_oe && board_sel_n && !reg_we && !reg_re, "R1",
          "outputs after reset", int'({dtack_oe, data_oe, board_sel_n}), 1);

    // short space write and read back, upper lines random
    run_cycle(1'b1, 6'h29, {8'hA5, 15'h6003}, 16'h1234, 1'b1, 1'b1, "R2");
    run_cycle(1'b0, 6'h2D, {8'h17, 15'h6003}, 16'h0, 1'b1, 1'b1, "R2");
    // standard space
    run_cycle(1'b1, 6'h39, {8'h3A, 15'h0009}, 16'hBEEF, 1'b1, 1'b1, "R3");
    run_cycle(1'b0, 6'h3D, {8'h3A, 15'h0009}, 16'h0, 1'b1, 1'b1, "R3");
    // ignored cycles
    run_cycle(1'b1, 6'h29, {8'h00, 15'h6010}, 16'hDEAD, 1'b1, 1'b1, "R4");
    run_cycle(1'b1, 6'h09, {8'h00, 15'h6001}, 16'hDEAD, 1'b1, 1'b1, "R4");
    run_cycle(1'b1, 6'h39, {8'h3B, 15'h0001}, 16'hDEAD, 1'b1, 1'b1, "R4");
    run_cycle(1'b1, 6'h29, {8'h00, 15'h6001}, 16'hDEAD, 1'b0, 1'b1, "R4");
    run_cycle(1'b1, 6'h29, {8'h00, 15'h6001}, 16'hDEAD, 1'b1, 1'b0, "R4");

    // single strobe: no access
    begin
      int we0, re0;
      we0 = we_cnt; re0 = re_cnt;
      @(negedge clk);
      am = 6'h29; addr = {8'h00, 15'h6002}; write_n = 1'b0; din = 16'h5555;
      iack_n = 1'b1; lword_n = 1'b1;
      @(negedge clk); as_n = 1'b0;
      repeat (3) @(negedge clk); ds_n = 2'b10;
      any = 0;
      repeat (15) begin
        @(negedge clk);
        if (dtack_oe || reg_we || reg_re) any = 1;
      end
      check(any == 0 && we_cnt == we0 && re_cnt == re0, "R5", "single strobe access",
            we_cnt - we0, 0);
      idle_bus();
    end

    // address strobe withdrawn before data strobes
    begin
      int we0, re0;
      we0 = we_cnt; re0 = re_cnt;
      @(negedge clk);
      am = 6'h39; addr = {8'h3A, 15'h0004}; write_n = 1'b0; din = 16'h7777;
      @(negedge clk); as_n = 1'b0;
      repeat (6) @(negedge clk);
      check(!board_sel_n, "R9", "select during matched wait", int'(board_sel_n), 0);
      as_n = 1'b1;
      repeat (6) @(negedge clk);
      check(board_sel_n && we_cnt == we0 && re_cnt == re0 && !dtack_oe, "R10",
            "aborted cycle", we_cnt - we0, 0);
      run_cycle(1'b0, 6'h39, {8'h3A, 15'h0004}, 16'h0, 1'b1, 1'b1, "R10");
    end

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [5:0] m;
      bit ia, lw, wr;
      m = pick_am($urandom_range(0, 5));
      a = 23'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        if (m[4]) a[23:AW+1] = B24[23:AW+1];
        else      a[15:AW+1] = B16[15:AW+1];
      end
      ia = ($urandom_range(0, 9) != 0);
      lw = ($urandom_range(0, 9) != 0);
      wr = $urandom_range(0, 1) == 1;
      run_cycle(wr, m, a, 16'($urandom), ia, lw,
                exp_hit(m, a, ia, lw) ? (m[4] ? "R3" : "R2") : "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule